// File: doc/BRIEF.md
# Eight-Port Omega Switching Network

This block moves packets from eight source ports to eight destination ports through three layers of two-by-two switch elements. Before every layer the eight lines are permuted by a perfect shuffle. Each element steers a packet to its upper or lower output using one bit of the packet's 3-bit destination. After the last layer a packet sits on the output line whose index equals its destination. The element count grows as N log N and the depth as log N. The price is that the network blocks: two packets that want the same element output in the same cycle cannot both move.

Every port uses a valid/ready handshake and carries a destination field and a payload. Each element output has one register, so the network is also a three-deep pipeline. When two packets in one element pick the same output, the packet on the upper input wins. The other packet stays where it is, with its ready held low, and tries again on the next cycle. A per-layer conflict flag shows in the same cycle that such a clash happened.

Top module: `omega_net`

## Requirements
- R1: While reset is asserted and right after it, every out_valid bit is 0, every in_ready bit is 1 and stage_conflict is 0.
- R2: A packet accepted on any input with destination d (in_dest bits [3i+2:3i] for input i) leaves on output d with its 8-bit payload unchanged.
- R3: With no contention and out_ready high, a packet accepted at a clock edge shows on its output after the third rising edge, counting the accepting edge, and not earlier.
- R4: Input i and input i+4 (i = 0..3) share a first-layer element, with input i on its upper side. The first layer routes on destination bit 2. When both are valid with equal bit 2, in_ready of input i+4 is 0 in that cycle.
- R5: A packet that loses a clash is kept, moves on the next cycle if its target is free, and arrives one cycle after the winner.
- R6: The identity permutation and every permutation d = i XOR c pass all eight packets in the same cycle with no conflict flag raised.
- R7: While out_ready of an output is 0, its out_valid and out_data hold steady. Packets queue behind it, one per register on the path, and then in_ready of the feeding input drops to 0.
- R8: Under mixed random traffic and random back-pressure, every accepted packet is delivered exactly once and no packet appears that was never accepted.
- R9: stage_conflict bit k is 1 in exactly those cycles in which some element of layer k has two valid inputs that ask for the same output. Layer k routes on destination bit 2-k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 8 | Per-input packet present |
| in_ready | output | 8 | Per-input packet taken at this edge |
| in_dest | input | 24 | Destination of input i at bits [3i+2:3i] |
| in_data | input | 64 | Payload of input i at bits [8i+7:8i] |
| out_valid | output | 8 | Per-output packet present |
| out_ready | input | 8 | Per-output sink takes the packet |
| out_data | output | 64 | Payload of output o at bits [8o+7:8o] |
| stage_conflict | output | 3 | Per-layer clash flag, bit k for layer k |

## Verification
The in_ready and stage_conflict signals are combinational on the current inputs. The bench reads them 1 ns after it drives at the falling edge, which is the cycle the clash belongs to. A packet accepted at rising edge E is due on its output after edge E+2. The bench therefore looks for it at the third falling edge after the drive and checks that it is absent at the two before. A loser of a clash is due one falling edge later than the winner. A second-layer clash is read at the first falling edge after acceptance. Random traffic is scored at delivery time against a table keyed by a unique payload tag, so arrival order across sources does not matter.

// File: rtl/omega_pkg.sv
package omega_pkg;
  // Perfect shuffle: one-bit left rotation of an lg-bit line index.
  function automatic int shuf_line(input int idx, input int lg);
    int msk;
    msk = (1 << lg) - 1;
    return ((idx << 1) | (idx >> (lg - 1))) & msk;
  endfunction

  // Destination bit examined by layer k (most significant first).
  function automatic int route_bit(input int k, input int lg);
    return lg - 1 - k;
  endfunction
endpackage

// File: rtl/omega_sw2.sv
module omega_sw2 #(
  parameter int AW  = 3,
  parameter int PW  = 8,
  parameter int SEL = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   a_vld,
  input  logic [AW-1:0]          a_dst,
  input  logic [PW-1:0]          a_pl,
  output logic                   a_rdy,
  input  logic                   b_vld,
  input  logic [AW-1:0]          b_dst,
  input  logic [PW-1:0]          b_pl,
  output logic                   b_rdy,
  input  logic [1:0]             dn_rdy,
  output logic [1:0]             q_vld,
  output logic [1:0][AW-1:0]     q_dst,
  output logic [1:0][PW-1:0]     q_pl,
  output logic                   clash
);
  logic       ra, rb, same;
  logic       acc_a, acc_b;
  logic [1:0] can_load, take_a, take_b, ld;

  assign ra       = a_dst[SEL];
  assign rb       = b_dst[SEL];
  assign same     = (ra == rb);
  assign can_load = ~q_vld | dn_rdy;

  // upper input has priority; lower yields whenever both aim at one output
  assign a_rdy = can_load[ra];
  assign b_rdy = can_load[rb] && !(a_vld && same);
  assign clash = a_vld && b_vld && same;

  assign acc_a  = a_vld && a_rdy;
  assign acc_b  = b_vld && b_rdy;
  assign take_a = acc_a ? (ra ? 2'b10 : 2'b01) : 2'b00;
  assign take_b = acc_b ? (rb ? 2'b10 : 2'b01) : 2'b00;
  assign ld     = can_load & (take_a | take_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= '0;
      q_dst <= '0;
      q_pl  <= '0;
    end else begin
      for (int o = 0; o < 2; o++) begin
        if (can_load[o]) begin
          q_vld[o] <= ld[o];
          if (take_a[o]) begin
            q_dst[o] <= a_dst;
            q_pl[o]  <= a_pl;
          end else if (take_b[o]) begin
            q_dst[o] <= b_dst;
            q_pl[o]  <= b_pl;
          end
        end
      end
    end
  end

  // R4
  lower_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> !b_rdy);

  // R8
  no_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ld) == $countones({acc_a, acc_b}));

  for (genvar g = 0; g < 2; g++) begin : g_hold
    // R7
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_vld[g] && !dn_rdy[g] |=> q_vld[g] && $stable(q_pl[g]) && $stable(q_dst[g]));
  end
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int LG = 3,
  parameter int PW = 8,
  parameter int K  = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [(1<<LG)-1:0]            up_vld,
  input  logic [(1<<LG)-1:0][LG-1:0]    up_dst,
  input  logic [(1<<LG)-1:0][PW-1:0]    up_pl,
  output logic [(1<<LG)-1:0]            up_rdy,
  output logic [(1<<LG)-1:0]            dn_vld,
  output logic [(1<<LG)-1:0][LG-1:0]    dn_dst,
  output logic [(1<<LG)-1:0][PW-1:0]    dn_pl,
  input  logic [(1<<LG)-1:0]            dn_rdy,
  output logic                          clash
);
  localparam int N   = 1 << LG;
  localparam int NE  = N / 2;
  localparam int SEL = omega_pkg::route_bit(K, LG);

  logic [N-1:0]          sh_vld, sh_rdy;
  logic [N-1:0][LG-1:0]  sh_dst;
  logic [N-1:0][PW-1:0]  sh_pl;
  logic [NE-1:0]         el_clash;

  for (genvar i = 0; i < N; i++) begin : g_shuf
    localparam int SI = omega_pkg::shuf_line(i, LG);
    assign sh_vld[SI] = up_vld[i];
    assign sh_dst[SI] = up_dst[i];
    assign sh_pl[SI]  = up_pl[i];
    assign up_rdy[i]  = sh_rdy[SI];
  end

  for (genvar e = 0; e < NE; e++) begin : g_el
    omega_sw2 #(.AW(LG), .PW(PW), .SEL(SEL)) u_sw (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_vld  (sh_vld[2*e]),
      .a_dst  (sh_dst[2*e]),
      .a_pl   (sh_pl[2*e]),
      .a_rdy  (sh_rdy[2*e]),
      .b_vld  (sh_vld[2*e+1]),
      .b_dst  (sh_dst[2*e+1]),
      .b_pl   (sh_pl[2*e+1]),
      .b_rdy  (sh_rdy[2*e+1]),
      .dn_rdy (dn_rdy[2*e+1:2*e]),
      .q_vld  (dn_vld[2*e+1:2*e]),
      .q_dst  (dn_dst[2*e+1:2*e]),
      .q_pl   (dn_pl[2*e+1:2*e]),
      .clash  (el_clash[e])
    );
  end

  assign clash = |el_clash;

  // R9
  clash_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> $countones(sh_vld) >= 2);
endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int LG = 3,
  parameter int PW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [(1<<LG)-1:0]        in_valid,
  output logic [(1<<LG)-1:0]        in_ready,
  input  logic [(1<<LG)*LG-1:0]     in_dest,
  input  logic [(1<<LG)*PW-1:0]     in_data,
  output logic [(1<<LG)-1:0]        out_valid,
  input  logic [(1<<LG)-1:0]        out_ready,
  output logic [(1<<LG)*PW-1:0]     out_data,
  output logic [LG-1:0]             stage_conflict
);
  localparam int N = 1 << LG;

  logic [N-1:0]          lv [LG+1];
  logic [N-1:0]          lr [LG+1];
  logic [N-1:0][LG-1:0]  ld [LG+1];
  logic [N-1:0][PW-1:0]  lp [LG+1];

  assign lv[0]     = in_valid;
  assign ld[0]     = in_dest;
  assign lp[0]     = in_data;
  assign in_ready  = lr[0];
  assign lr[LG]    = out_ready;
  assign out_valid = lv[LG];
  assign out_data  = lp[LG];

  for (genvar k = 0; k < LG; k++) begin : g_stage
    omega_stage #(.LG(LG), .PW(PW), .K(k)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .up_vld (lv[k]),
      .up_dst (ld[k]),
      .up_pl  (lp[k]),
      .up_rdy (lr[k]),
      .dn_vld (lv[k+1]),
      .dn_dst (ld[k+1]),
      .dn_pl  (lp[k+1]),
      .dn_rdy (lr[k+1]),
      .clash  (stage_conflict[k])
    );
  end

  for (genvar o = 0; o < N; o++) begin : g_out_chk
    // R2
    route_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lv[LG][o] |-> ld[LG][o] == LG'(o));
  end
endmodule

// File: tb/tb_omega_net.sv
module tb_omega_net;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_valid = '0;
  logic [7:0]  in_ready;
  logic [23:0] in_dest = '0;
  logic [63:0] in_data = '0;
  logic [7:0]  out_valid;
  logic [7:0]  out_ready = '1;
  logic [63:0] out_data;
  logic [2:0]  stage_conflict;

  omega_net dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .stage_conflict(stage_conflict)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  bit       pend [256];
  int       exp_dst [256];
  int       tag_ctr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int new_tag();
    tag_ctr = (tag_ctr + 1) % 256;
    return tag_ctr;
  endfunction

  task automatic drive(input int i, input bit v, input int d, input int tag);
    in_valid[i]        = v;
    in_dest[i*3 +: 3]  = 3'(d);
    in_data[i*8 +: 8]  = 8'(tag);
  endtask

  function automatic int dst_of(input int i);
    return int'(in_dest[i*3 +: 3]);
  endfunction

  // first-layer pairing: inputs e and e+4, routed on destination bit 2
  function automatic bit exp_clash0();
    for (int e = 0; e < 4; e++)
      if (in_valid[e] && in_valid[e+4] && (dst_of(e) >> 2) == (dst_of(e+4) >> 2))
        return 1'b1;
    return 1'b0;
  endfunction

  function automatic int pending_cnt();
    int c = 0;
    for (int t = 0; t < 256; t++) if (pend[t]) c++;
    return c;
  endfunction

  // scoreboard: record acceptances, score deliveries (R2, R8)
  always @(negedge clk) begin
    #2;
    if (mon_en) begin
      for (int i = 0; i < 8; i++)
        if (in_valid[i] && in_ready[i]) begin
          pend[int'(in_data[i*8 +: 8])]    = 1'b1;
          exp_dst[int'(in_data[i*8 +: 8])] = dst_of(i);
        end
      for (int o = 0; o < 8; o++)
        if (out_valid[o] && out_ready[o]) begin
          int t;
          t = int'(out_data[o*8 +: 8]);
          chk(pend[t] && exp_dst[t] == o, "R2/R8 delivery", o, pend[t] ? exp_dst[t] : -1);
          pend[t] = 1'b0;
        end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int extra;
    int held;
    bit [7:0] took;
    void'($urandom(32'd20251));
    for (int t = 0; t < 256; t++) begin pend[t] = 1'b0; exp_dst[t] = 0; end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 8'h00, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready == 8'hFF, "R1 in_ready in reset", in_ready, 255);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 8'h00 && stage_conflict == 3'b000, "R1 after reset", out_valid, 0);
    chk(in_ready == 8'hFF, "R1 in_ready after reset", in_ready, 255);
    mon_en = 1'b1;

    // R3: latency, input 3 to output 5
    drive(3, 1, 5, new_tag());
    #1 chk(in_ready[3], "R3 accept", in_ready[3], 1);
    @(negedge clk); drive(3, 0, 0, 0);
    chk(!out_valid[5], "R3 early at 1", out_valid[5], 0);
    @(negedge clk);
    chk(!out_valid[5], "R3 early at 2", out_valid[5], 0);
    @(negedge clk);
    chk(out_valid[5] && out_data[47:40] == 8'(tag_ctr), "R3 due at 3", out_valid[5], 1);
    repeat (2) @(negedge clk);

    // R4/R5/R9: first-layer clash, inputs 0 (dest 1) and 4 (dest 2)
    drive(0, 1, 1, new_tag());
    drive(4, 1, 2, new_tag());
    #1;
    chk(stage_conflict[0], "R9 layer0 flag", stage_conflict, 1);
    chk(in_ready[0] && !in_ready[4], "R4 upper wins", in_ready[4], 0);
    @(negedge clk); drive(0, 0, 0, 0);
    #1;
    chk(in_ready[4] && !stage_conflict[0], "R5 retry accepted", in_ready[4], 1);
    @(negedge clk); drive(4, 0, 0, 0);
    @(negedge clk);
    chk(out_valid[1] && !out_valid[2], "R5 winner first", out_valid, 2);
    @(negedge clk);
    chk(out_valid[2], "R5 loser one later", out_valid[2], 1);
    repeat (2) @(negedge clk);

    // R9: second-layer clash, input 0 (dest 0) and input 2 (dest 1)
    drive(0, 1, 0, new_tag());
    drive(2, 1, 1, new_tag());
    #1 chk(stage_conflict == 3'b000 && in_ready[0] && in_ready[2], "R9 layer0 quiet", stage_conflict, 0);
    @(negedge clk); drive(0, 0, 0, 0); drive(2, 0, 0, 0);
    #1 chk(stage_conflict[1], "R9 layer1 flag", stage_conflict, 2);
    @(negedge clk);
    @(negedge clk);
    chk(out_valid[0] && !out_valid[1], "R5 layer1 winner", out_valid, 1);
    @(negedge clk);
    chk(out_valid[1], "R5 layer1 loser", out_valid[1], 1);
    repeat (2) @(negedge clk);

    // R6: identity and XOR permutations
    for (int c = 0; c < 8; c += 5) begin
      for (int i = 0; i < 8; i++) drive(i, 1, i ^ c, new_tag());
      #1 chk(in_ready == 8'hFF && stage_conflict == 3'b000, "R6 all accepted", in_ready, 255);
      @(negedge clk);
      for (int i = 0; i < 8; i++) drive(i, 0, 0, 0);
      #1 chk(stage_conflict == 3'b000, "R6 no clash layer1", stage_conflict, 0);
      @(negedge clk);
      #1 chk(stage_conflict == 3'b000, "R6 no clash layer2", stage_conflict, 0);
      @(negedge clk);
      chk(out_valid == 8'hFF, "R6 all arrive together", out_valid, 255);
      repeat (2) @(negedge clk);
    end

    // R7: back-pressure on output 5 from input 0
    out_ready[5] = 1'b0;
    drive(0, 1, 5, new_tag());
    @(negedge clk); drive(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk(out_valid[5], "R7 head present", out_valid[5], 1);
    held = int'(out_data[47:40]);
    extra = 0;
    took = '0;
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || took[0]) drive(0, 1, 5, new_tag());
      #1 took[0] = in_ready[0];
      if (took[0]) extra++;
      @(negedge clk);
    end
    chk(extra == 2, "R7 queue depth", extra, 2);
    chk(!in_ready[0], "R7 in_ready low", in_ready[0], 0);
    chk(out_valid[5] && int'(out_data[47:40]) == held, "R7 head stable", out_data[47:40], held);
    drive(0, 0, 0, 0);
    out_ready[5] = 1'b1;
    repeat (6) @(negedge clk);
    chk(pending_cnt() == 0, "R7 drained", pending_cnt(), 0);

    // R8/R4/R9: random traffic and back-pressure
    took = '0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int i = 0; i < 8; i++)
        if (!in_valid[i] || took[i]) begin
          if ($urandom % 3 != 0) drive(i, 1, int'($urandom % 8), new_tag());
          else drive(i, 0, 0, 0);
        end
      out_ready = 8'($urandom | $urandom);
      #1;
      took = in_valid & in_ready;
      chk(stage_conflict[0] == exp_clash0(), "R9 layer0 random", stage_conflict[0], exp_clash0());
      for (int e = 0; e < 4; e++)
        if (in_valid[e] && in_valid[e+4] && (dst_of(e) >> 2) == (dst_of(e+4) >> 2))
          chk(!in_ready[e+4], "R4 random", in_ready[e+4], 0);
      @(negedge clk);
    end
    in_valid = '0;
    out_ready = '1;
    repeat (10) @(negedge clk);
    chk(pending_cnt() == 0, "R8 all delivered", pending_cnt(), 0);
    chk(out_valid == 8'h00, "R8 empty", out_valid, 0);
    finish_run();
  end
endmodule